// File: doc/BRIEF.md
# Composite Sync Polarity Detector and Vertical Separator

This block sits behind a digital horizontal or composite sync input and runs on the system clock. A slow up/down integrator finds the polarity of the raw input. The block then turns the input into an active-high sync and marks the start of each pulse with a one-cycle strobe. A line period count, measured elsewhere, is supplied alongside the sync.

Composite sync is split by pulse width. Each normalized pulse is timed in clock cycles. Once its width passes about 31% of the line period, the pulse is taken as vertical sync. While that pulse lasts, and for two whole lines after it, the block raises an inhibit that freezes the horizontal phase detector downstream. A control input can disable the inhibit. The detected polarity and a sticky composite-seen flag are presented as register-visible outputs.

Top module: `csync_separator`

## Requirements
- R1: After reset, `pol_neg`, `comp_det`, `vsync_out`, `inhibit`, `sync_pos` and `lead_strobe` are 0. The period latch resets to all ones, so no pulse is classified before the first line start.
- R2: A saturating integrator of IW bits starts at 0 after reset. On each clock it counts up while `sync_in` is 1 and down while it is 0. `pol_neg` is 1 exactly when the count is at least 2^(IW-1). From the reset state, a high level on `sync_in` that lasts fewer than 2^(IW-1) cycles leaves `pol_neg` at 0.
- R3: `sync_pos` equals `sync_in` XOR `pol_neg`, both taken in the previous cycle, registered once.
- R4: `lead_strobe` is high for exactly one cycle, in the first cycle that `sync_pos` is high after being low.
- R5: `period` is latched on each cycle where `lead_strobe` is high. The threshold is (latched period × 5) >> 4. A pulse width counter resets while `sync_pos` is low and counts cycles while it is high. `vsync_out` is set once the counter is at or above the threshold while `sync_pos` is high. It clears one cycle after `sync_pos` falls.
- R6: `comp_det` is set by the first extracted vertical sync. It then stays set until reset.
- R7: With `inhib_en` high, `inhibit` is high while `vsync_out` is high. After `vsync_out` falls, it stays high until the third `lead_strobe`, and drops in the cycle that follows that strobe.
- R8: With `inhib_en` low, `inhibit` stays 0 through vertical sync and the lines after it.
- R9: Sync pulses narrower than the threshold never raise `vsync_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Raw digital H or composite sync, either polarity |
| period | input | PW | Measured line period in clock cycles |
| inhib_en | input | 1 | Enables the phase-detector inhibit |
| sync_pos | output | 1 | Active-high normalized sync |
| lead_strobe | output | 1 | One-cycle marker on the leading edge |
| vsync_out | output | 1 | Vertical sync extracted from composite sync |
| inhibit | output | 1 | Phase-detector freeze window |
| pol_neg | output | 1 | 1 when the input sync is active-low |
| comp_det | output | 1 | Sticky flag: composite vertical sync seen |

## Verification
The separator is driven with four kinds of input:

- **Plain positive line pulses.** These confirm that narrow pulses are never taken as vertical sync.
- **A single wide pulse shorter than the integrator half-range.** This shows the pulse is classified but the polarity does not flip.
- **Composite frames with a pulse spanning several lines.** These are run with the inhibit enabled and with it disabled, which separates the vertical window from the two-line extension.
- **The same streams inverted.** These show the polarity flip, and that normalization then carries the whole chain.

Every cycle is compared against a behavioural model, so edge timing is checked as well as levels.

// File: rtl/csync_separator.sv
module csync_separator #(
  parameter int PW = 12,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_in,
  input  logic [PW-1:0] period,
  input  logic          inhib_en,
  output logic          sync_pos,
  output logic          lead_strobe,
  output logic          vsync_out,
  output logic          inhibit,
  output logic          pol_neg,
  output logic          comp_det
);
  localparam int TW = PW + 3;

  logic [IW-1:0] integ;
  logic          s_r, s_d, vs, comp;
  logic [PW-1:0] wcnt, per_q, thr;
  logic [TW-1:0] thr_full;
  logic [1:0]    post;
  logic          hit;

  assign pol_neg     = integ[IW-1];
  assign thr_full    = ({3'b000, per_q} << 2) + {3'b000, per_q};
  assign thr         = PW'(thr_full >> 4);
  assign hit         = s_r && (wcnt >= thr);
  assign sync_pos    = s_r;
  assign lead_strobe = s_r & ~s_d;
  assign vsync_out   = vs;
  assign comp_det    = comp;
  assign inhibit     = inhib_en & (vs | (post != 2'd0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ <= '0;
      s_r   <= 1'b0;
      s_d   <= 1'b0;
      wcnt  <= '0;
      per_q <= '1;
      vs    <= 1'b0;
      comp  <= 1'b0;
      post  <= 2'd0;
    end else begin
      if (sync_in && integ != '1)       integ <= integ + 1'b1;
      else if (!sync_in && integ != '0) integ <= integ - 1'b1;
      s_r <= sync_in ^ pol_neg;
      s_d <= s_r;
      if (!s_r)            wcnt <= '0;
      else if (wcnt != '1) wcnt <= wcnt + 1'b1;
      if (lead_strobe) per_q <= period;
      vs   <= s_r && (vs || wcnt >= thr);
      comp <= comp | hit;
      if (vs)                             post <= 2'd3;
      else if (lead_strobe && post != '0) post <= post - 1'b1;
    end
  end

  // R4
  a_r4_lead_single: assert property (@(posedge clk) disable iff (!rst_n)
    lead_strobe |=> !lead_strobe);
  // R5
  a_r5_vs_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |-> $past(sync_pos));
  // R6
  a_r6_comp_on_vs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_out) |-> comp_det);
  // R6
  a_r6_comp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    comp_det |=> comp_det);
  // R7
  a_r7_release_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(inhibit) && inhib_en && $past(inhib_en)) |-> $past(lead_strobe));
endmodule

// File: tb/tb_csync_separator.sv
`timescale 1ns/1ps
module tb_csync_separator;
  localparam int PW   = 8;
  localparam int IW   = 6;
  localparam int PER  = 64;
  localparam int HALF = 1 << (IW - 1);
  localparam int IMAX = (1 << IW) - 1;
  localparam int WMAX = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic [PW-1:0] period = PW'(PER);
  logic inhib_en = 1'b1;
  logic sync_pos, lead_strobe, vsync_out, inhibit, pol_neg, comp_det;

  csync_separator #(.PW(PW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .period(period),
    .inhib_en(inhib_en), .sync_pos(sync_pos), .lead_strobe(lead_strobe),
    .vsync_out(vsync_out), .inhibit(inhibit), .pol_neg(pol_neg), .comp_det(comp_det));

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit vs_seen = 0;
  bit inh_seen = 0;

  int m_int, m_sr, m_sd, m_w, m_per, m_vs, m_post, m_comp;

  always @(posedge clk) begin
    int pol, lead, thr, n_int, n_sr, n_w, n_per, n_vs, n_post, n_comp;
    if (!rst_n) begin
      m_int = 0; m_sr = 0; m_sd = 0; m_w = 0; m_per = WMAX;
      m_vs = 0; m_post = 0; m_comp = 0;
    end else begin
      pol  = (m_int >= HALF);
      lead = m_sr && !m_sd;
      thr  = (m_per * 5) / 16;
      n_int = sync_in ? ((m_int < IMAX) ? m_int + 1 : m_int)
                      : ((m_int > 0) ? m_int - 1 : 0);
      n_sr  = int'(sync_in) ^ pol;
      n_w   = !m_sr ? 0 : ((m_w < WMAX) ? m_w + 1 : m_w);
      n_per = lead ? PER : m_per;
      n_vs  = m_sr && (m_vs || m_w >= thr);
      n_post = m_vs ? 3 : ((lead && m_post > 0) ? m_post - 1 : m_post);
      n_comp = m_comp || (m_sr && m_w >= thr);
      m_sd = m_sr; m_int = n_int; m_sr = n_sr; m_w = n_w; m_per = n_per;
      m_vs = n_vs; m_post = n_post; m_comp = n_comp;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 pol_neg", int'(pol_neg), int'(m_int >= HALF));
    chk("R3 sync_pos", int'(sync_pos), m_sr);
    chk("R4 lead_strobe", int'(lead_strobe), int'(m_sr && !m_sd));
    chk("R5 vsync_out", int'(vsync_out), m_vs);
    chk("R6 comp_det", int'(comp_det), m_comp);
    chk("R7 inhibit", int'(inhibit), int'(inhib_en && (m_vs || m_post > 0)));
    if (vsync_out) vs_seen = 1;
    if (inhibit) inh_seen = 1;
  end

  task automatic line(input bit act, input int width);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      sync_in = (i < width) ? act : ~act;
    end
  endtask

  task automatic frame(input bit act);
    for (int k = 0; k < 3; k++) line(act, 6);
    for (int i = 0; i < 3 * PER; i++) begin
      @(negedge clk);
      sync_in = (i < 3 * PER - 6) ? act : ~act;
    end
    for (int k = 0; k < 5; k++) line(act, 6);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset pol_neg", int'(pol_neg), 0);
    chk("R1 reset comp_det", int'(comp_det), 0);
    chk("R1 reset inhibit", int'(inhibit), 0);
    chk("R1 reset vsync_out", int'(vsync_out), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) line(1'b1, 6);
    chk("R9 narrow pulses no vsync", int'(vs_seen), 0);
    for (int i = 0; i < HALF + 20; i++) begin
      @(negedge clk);
      sync_in = (i < HALF - 2);
    end
    chk("R2 short high keeps positive", int'(pol_neg), 0);
    line(1'b1, 6);
    frame(1'b1);
    chk("R6 composite flagged", int'(comp_det), 1);
    chk("R7 inhibit released", int'(inhibit), 0);
    inhib_en = 1'b0;
    inh_seen = 0;
    vs_seen = 0;
    frame(1'b1);
    chk("R8 inhibit held off", int'(inh_seen), 0);
    chk("R5 vsync in disabled frame", int'(vs_seen), 1);
    inhib_en = 1'b1;
    for (int k = 0; k < 6; k++) line(1'b0, 6);
    chk("R2 negative polarity found", int'(pol_neg), 1);
    frame(1'b0);
    chk("R6 still flagged", int'(comp_det), 1);
    chk("R2 stays negative", int'(pol_neg), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule